// File: doc/BRIEF.md
# Exception Entry Vector and Cause Update Unit

This block handles the moment a processor takes an exception. On a one-cycle strobe it takes the exception kind, the faulting PC, the delay-slot, 16-bit-branch and compressed-ISA flags, and the refill-miss flag. It also takes the current Status, Cause, exception base and vector spacing values and the pending interrupt lines. From these it computes the handler entry address. It returns updated Status and Cause words: the exception code is set, the branch-delay flag is updated, the exception, error and boot-vector flags are set, and the privilege field is forced to kernel. It also captures the return address into one of three return-PC registers: ordinary, error or debug.

Ordinary exceptions use a base address that depends on the boot-vector flag, plus a per-kind offset. A TLB refill gets its own low offset, but only when no exception is already in progress. Interrupts may use a fixed offset or a vectored offset. The vectored offset is scaled by the programmed spacing. The vector number comes from an internal priority search or from an external controller. NMI and soft reset go to the reset vector, and debug-class entries go to the debug vector. A kind code outside the table raises a one-cycle error pulse and leaves every register as it was.

Top module: `trap_vector_unit`

## Requirements
- R1: While reset (rstN low) is applied and after it, until the first strobe, every output is zero.
- R2: Results appear one clock after the strobe, and takenOut pulses for that one cycle. The base is 0xBFC00200 when BEV (Status bit 22) is set; otherwise it is ebaseIn with bits 9:0 cleared. Ordinary kinds use offset 0x180.
- R3: A TLB load (kind 2) or TLB store (kind 3) with refillMiss high and EXL (Status bit 1) clear uses offset 0x000. With EXL set, the same fault uses 0x180.
- R4: An interrupt (kind 0) with both vectored modes off uses offset 0x200 when IV (Cause bit 23) is set, and 0x180 when it is clear.
- R5: When vecInt is high, the vector is the highest line from 7 down to 1 of irqPend ANDed with Status bits 15:8, or 0 if none of those is set. Otherwise, when vecExt is high, the vector is that masked value itself. The interrupt offset is 0x200 + vector × vsIn × 32.
- R6: Cause bits 6:2 receive the code for the kind. Kinds 0 to 13 give the same value as the kind. Kind 14 (floating point) gives 15, and kind 15 (cache error) gives 30. The other Cause bits pass through except where R7, R9, R10 and R12 change them.
- R7: For kinds 0 to 15 with EXL clear, epcOut takes the resume PC. BD (Cause bit 31) takes inDelaySlot, EXL is set, and KSU (Status bits 4:3) is cleared. With EXL set, epcOut, BD, EXL and KSU are left unchanged.
- R8: The resume PC is curPc with isaMode ORed into bit 0. When inDelaySlot is high, 2 is subtracted if branch16 is high and 4 otherwise.
- R9: NMI (kind 16) and soft reset (kind 17) load errorEpcOut with the resume PC. They set ERL (Status bit 2) and BEV, clear KSU, clear BD if EXL was clear, and jump to 0xBFC00000. Soft reset also sets SR (Status bit 20).
- R10: A debug-class entry (kind 18) loads depcOut with the resume PC, clears KSU, clears BD if EXL was clear, leaves EXL as it was, and jumps to 0xBFC00480.
- R11: A cache error (kind 15) uses offset 0x100 when BEV is set and 0x20000100 when BEV is clear.
- R12: Coprocessor unusable (kind 11) writes cpNum into Cause bits 29:28.
- R13: A kind of 19 or above pulses errOut for one cycle, keeps takenOut low, and leaves every register output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | Exception strobe, one cycle |
| excKind | input | 5 | Exception kind code |
| curPc | input | 32 | PC of the faulting instruction |
| inDelaySlot | input | 1 | Fault occurred in a branch delay slot |
| branch16 | input | 1 | The branch owning the slot is 16 bits |
| isaMode | input | 1 | Compressed-ISA mode bit |
| refillMiss | input | 1 | TLB fault was a missing entry |
| cpNum | input | 2 | Coprocessor number for coprocessor unusable |
| statusIn | input | 32 | Current Status word |
| causeIn | input | 32 | Current Cause word |
| ebaseIn | input | 32 | Exception base register |
| vsIn | input | VS_W | Vector spacing in units of 32 bytes |
| irqPend | input | 8 | Pending interrupt lines |
| vecInt | input | 1 | Internal vectored interrupt mode |
| vecExt | input | 1 | External-controller vectored mode |
| pcOut | output | 32 | Handler entry PC |
| statusOut | output | 32 | Updated Status word |
| causeOut | output | 32 | Updated Cause word |
| epcOut | output | 32 | Ordinary return PC |
| errorEpcOut | output | 32 | Error return PC |
| depcOut | output | 32 | Debug return PC |
| takenOut | output | 1 | Exception accepted pulse |
| errOut | output | 1 | Unknown kind pulse |

## Verification
Every result of this block appears exactly one clock after the strobe. The handler PC, both words, the three return PCs and the two pulses are all registered at the edge that samples the strobe. The bench drives each stimulus on a falling edge and lets one rising edge pass. It compares on the next falling edge, then drops the strobe at that same point, so each pulse is seen in its only valid cycle. Idle cycles between strobes are also compared, so that a register that moves without a strobe is caught.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int IRQ_N       = 8;
  localparam int SPACE_SHIFT = 5;

  typedef enum logic [4:0] {
    K_INT = 5'd0, K_MOD = 5'd1, K_TLBL = 5'd2, K_TLBS = 5'd3,
    K_ADEL = 5'd4, K_ADES = 5'd5, K_IBE = 5'd6, K_DBE = 5'd7,
    K_SYS = 5'd8, K_BRK = 5'd9, K_RI = 5'd10, K_CPU = 5'd11,
    K_OVF = 5'd12, K_TRAP = 5'd13, K_FPE = 5'd14, K_CACHE = 5'd15,
    K_NMI = 5'd16, K_SRST = 5'd17, K_DEBUG = 5'd18
  } excKind_e;

  // Status field positions
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_KSU_LO = 3;
  localparam int ST_IM_LO = 8;
  localparam int ST_SR = 20;
  localparam int ST_BEV = 22;
  // Cause field positions
  localparam int CA_EC_LO = 2;
  localparam int CA_IV = 23;
  localparam int CA_CE_LO = 28;
  localparam int CA_BD = 31;

  localparam logic [31:0] VEC_BOOT  = 32'hBFC0_0200;
  localparam logic [31:0] VEC_RESET = 32'hBFC0_0000;
  localparam logic [31:0] VEC_DEBUG = 32'hBFC0_0480;
  localparam logic [31:0] OFF_GEN   = 32'h0000_0180;
  localparam logic [31:0] OFF_INT   = 32'h0000_0200;
  localparam logic [31:0] OFF_CBOOT = 32'h0000_0100;
  localparam logic [31:0] OFF_CRUN  = 32'h2000_0100;

  typedef enum logic [2:0] {
    V_GEN, V_INT, V_REFILL, V_CACHE, V_RESET, V_DEBUG
  } vecSel_e;

  typedef struct packed {
    logic       commit;
    logic       flagErr;
    logic       saveEpc;
    logic       saveErrEpc;
    logic       saveDepc;
    logic       setSr;
    logic       forceKernel;
    logic       clrBd;
    logic       writeCode;
    logic       writeCe;
    logic [4:0] code;
    vecSel_e    vecSel;
  } trapCtl_t;

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic       excValid,
  input  logic [4:0] excKind,
  input  logic       exlIn,
  input  logic       refillMiss,
  output trapCtl_t   ctl
);

  logic known;
  logic ordinary;
  logic errClass;

  assign known    = excKind <= K_DEBUG;
  assign ordinary = excKind <= K_CACHE;
  assign errClass = (excKind == K_NMI) || (excKind == K_SRST);

  function automatic logic [4:0] codeOf(input logic [4:0] kind);
    case (kind)
      K_FPE:   codeOf = 5'd15;
      K_CACHE: codeOf = 5'd30;
      default: codeOf = kind;
    endcase
  endfunction

  always_comb begin
    ctl             = '0;
    ctl.vecSel      = V_GEN;
    ctl.commit      = excValid && known;
    ctl.flagErr     = excValid && !known;
    ctl.saveEpc     = ctl.commit && ordinary && !exlIn;
    ctl.saveErrEpc  = ctl.commit && errClass;
    ctl.saveDepc    = ctl.commit && (excKind == K_DEBUG);
    ctl.setSr       = ctl.commit && (excKind == K_SRST);
    ctl.forceKernel = ctl.commit && (!ordinary || !exlIn);
    ctl.clrBd       = ctl.commit && !ordinary && !exlIn;
    ctl.writeCode   = ctl.commit && ordinary;
    ctl.writeCe     = ctl.commit && (excKind == K_CPU);
    ctl.code        = codeOf(excKind);
    if (errClass)                              ctl.vecSel = V_RESET;
    else if (excKind == K_DEBUG)               ctl.vecSel = V_DEBUG;
    else if (excKind == K_INT)                 ctl.vecSel = V_INT;
    else if (excKind == K_CACHE)               ctl.vecSel = V_CACHE;
    else if ((excKind == K_TLBL || excKind == K_TLBS) && refillMiss && !exlIn)
                                               ctl.vecSel = V_REFILL;
  end

endmodule

// File: rtl/trap_irq_prio.sv
module trap_irq_prio #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = 1; i < N; i++) begin
      if (req[i]) idx = W'(i);
    end
  end

endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int VS_W = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  trapCtl_t        ctl,
  input  logic [31:0]     curPc,
  input  logic            inDelaySlot,
  input  logic            branch16,
  input  logic            isaMode,
  input  logic [1:0]      cpNum,
  input  logic [31:0]     statusIn,
  input  logic [31:0]     causeIn,
  input  logic [31:0]     ebaseIn,
  input  logic [VS_W-1:0] vsIn,
  input  logic [IRQ_N-1:0] irqPend,
  input  logic            vecInt,
  input  logic            vecExt,
  output logic [31:0]     pcOut,
  output logic [31:0]     statusOut,
  output logic [31:0]     causeOut,
  output logic [31:0]     epcOut,
  output logic [31:0]     errorEpcOut,
  output logic [31:0]     depcOut,
  output logic            takenOut,
  output logic            errOut
);

  localparam int PW = $clog2(IRQ_N);

  logic [IRQ_N-1:0] maskedIrq;
  logic [PW-1:0]    prioIdx;
  logic [IRQ_N-1:0] vecNum;
  logic [31:0]      spacing;
  logic [31:0]      base;
  logic [31:0]      intOff;
  logic [31:0]      offset;
  logic [31:0]      resumePc;
  logic [31:0]      nextPc;
  logic [31:0]      nextStatus;
  logic [31:0]      nextCause;

  assign maskedIrq = irqPend & statusIn[ST_IM_LO +: IRQ_N];

  trap_irq_prio #(.N(IRQ_N)) u_prio (
    .req (maskedIrq),
    .idx (prioIdx)
  );

  always_comb begin
    resumePc = curPc | {31'b0, isaMode};
    if (inDelaySlot) resumePc = resumePc - (branch16 ? 32'd2 : 32'd4);
  end

  always_comb begin
    base    = statusIn[ST_BEV] ? VEC_BOOT : (ebaseIn & ~32'h3FF);
    spacing = 32'(vsIn) << SPACE_SHIFT;
    if (vecInt)      vecNum = IRQ_N'(prioIdx);
    else if (vecExt) vecNum = maskedIrq;
    else             vecNum = '0;
    if (vecInt || vecExt)
      intOff = OFF_INT + 32'(vecNum) * spacing;
    else
      intOff = causeIn[CA_IV] ? OFF_INT : OFF_GEN;
    case (ctl.vecSel)
      V_INT:    offset = intOff;
      V_REFILL: offset = 32'h0;
      V_CACHE:  offset = statusIn[ST_BEV] ? OFF_CBOOT : OFF_CRUN;
      default:  offset = OFF_GEN;
    endcase
    case (ctl.vecSel)
      V_RESET: nextPc = VEC_RESET;
      V_DEBUG: nextPc = VEC_DEBUG;
      default: nextPc = base + offset;
    endcase
  end

  always_comb begin
    nextStatus = statusIn;
    if (ctl.saveEpc)     nextStatus[ST_EXL] = 1'b1;
    if (ctl.forceKernel) nextStatus[ST_KSU_LO +: 2] = 2'b00;
    if (ctl.saveErrEpc) begin
      nextStatus[ST_ERL] = 1'b1;
      nextStatus[ST_BEV] = 1'b1;
    end
    if (ctl.setSr)       nextStatus[ST_SR] = 1'b1;

    nextCause = causeIn;
    if (ctl.saveEpc)   nextCause[CA_BD] = inDelaySlot;
    if (ctl.clrBd)     nextCause[CA_BD] = 1'b0;
    if (ctl.writeCode) nextCause[CA_EC_LO +: 5] = ctl.code;
    if (ctl.writeCe)   nextCause[CA_CE_LO +: 2] = cpNum;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcOut       <= '0;
      statusOut   <= '0;
      causeOut    <= '0;
      epcOut      <= '0;
      errorEpcOut <= '0;
      depcOut     <= '0;
      takenOut    <= 1'b0;
      errOut      <= 1'b0;
    end else begin
      takenOut <= ctl.commit;
      errOut   <= ctl.flagErr;
      if (ctl.commit) begin
        pcOut     <= nextPc;
        statusOut <= nextStatus;
        causeOut  <= nextCause;
      end
      if (ctl.saveEpc)    epcOut      <= resumePc;
      if (ctl.saveErrEpc) errorEpcOut <= resumePc;
      if (ctl.saveDepc)   depcOut     <= resumePc;
    end
  end

endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
  import trap_pkg::*;
#(
  parameter int VS_W = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            excValid,
  input  logic [4:0]      excKind,
  input  logic [31:0]     curPc,
  input  logic            inDelaySlot,
  input  logic            branch16,
  input  logic            isaMode,
  input  logic            refillMiss,
  input  logic [1:0]      cpNum,
  input  logic [31:0]     statusIn,
  input  logic [31:0]     causeIn,
  input  logic [31:0]     ebaseIn,
  input  logic [VS_W-1:0] vsIn,
  input  logic [7:0]      irqPend,
  input  logic            vecInt,
  input  logic            vecExt,
  output logic [31:0]     pcOut,
  output logic [31:0]     statusOut,
  output logic [31:0]     causeOut,
  output logic [31:0]     epcOut,
  output logic [31:0]     errorEpcOut,
  output logic [31:0]     depcOut,
  output logic            takenOut,
  output logic            errOut
);

  trapCtl_t ctl;

  trap_ctrl u_ctrl (
    .excValid   (excValid),
    .excKind    (excKind),
    .exlIn      (statusIn[ST_EXL]),
    .refillMiss (refillMiss),
    .ctl        (ctl)
  );

  trap_datapath #(.VS_W(VS_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .curPc       (curPc),
    .inDelaySlot (inDelaySlot),
    .branch16    (branch16),
    .isaMode     (isaMode),
    .cpNum       (cpNum),
    .statusIn    (statusIn),
    .causeIn     (causeIn),
    .ebaseIn     (ebaseIn),
    .vsIn        (vsIn),
    .irqPend     (irqPend),
    .vecInt      (vecInt),
    .vecExt      (vecExt),
    .pcOut       (pcOut),
    .statusOut   (statusOut),
    .causeOut    (causeOut),
    .epcOut      (epcOut),
    .errorEpcOut (errorEpcOut),
    .depcOut     (depcOut),
    .takenOut    (takenOut),
    .errOut      (errOut)
  );

endmodule

// File: rtl/trap_vector_chk.sv
module trap_vector_chk
  import trap_pkg::*;
#(
  parameter int VS_W = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic            excValid,
  input logic [4:0]      excKind,
  input logic [31:0]     curPc,
  input logic            inDelaySlot,
  input logic            branch16,
  input logic            isaMode,
  input logic            refillMiss,
  input logic [1:0]      cpNum,
  input logic [31:0]     statusIn,
  input logic [31:0]     causeIn,
  input logic [31:0]     ebaseIn,
  input logic [VS_W-1:0] vsIn,
  input logic [7:0]      irqPend,
  input logic            vecInt,
  input logic            vecExt,
  input logic [31:0]     pcOut,
  input logic [31:0]     statusOut,
  input logic [31:0]     causeOut,
  input logic [31:0]     epcOut,
  input logic [31:0]     errorEpcOut,
  input logic [31:0]     depcOut,
  input logic            takenOut,
  input logic            errOut
);

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(takenOut && errOut)); // R13

  AST_TAKEN_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    takenOut |-> $past(excValid)); // R2

  AST_UNKNOWN_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> ($stable(pcOut) && $stable(statusOut) && $stable(causeOut) &&
                $stable(epcOut) && $stable(errorEpcOut) && $stable(depcOut))); // R13

  AST_NESTED_EPC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(excValid) && $past(excKind) <= K_CACHE && $past(statusIn[ST_EXL]))
      |-> $stable(epcOut)); // R7

  AST_EXL_SET_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(excValid) && $past(excKind) <= K_CACHE)
      |-> statusOut[ST_EXL]); // R7

  AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(excValid) && ($past(excKind) == K_NMI || $past(excKind) == K_SRST))
      |-> (pcOut == VEC_RESET && statusOut[ST_ERL] && statusOut[ST_BEV])); // R9

  AST_DEBUG_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(excValid) && $past(excKind) == K_DEBUG)
      |-> (pcOut == VEC_DEBUG && statusOut[ST_KSU_LO +: 2] == 2'b00)); // R10

endmodule

bind trap_vector_unit trap_vector_chk #(.VS_W(VS_W)) u_chk (.*);

// File: tb/sim_trap_vector_unit.sv
module sim_trap_vector_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excValid = 1'b0;
  logic [4:0]  excKind = '0;
  logic [31:0] curPc = '0;
  logic        inDelaySlot = 1'b0;
  logic        branch16 = 1'b0;
  logic        isaMode = 1'b0;
  logic        refillMiss = 1'b0;
  logic [1:0]  cpNum = '0;
  logic [31:0] statusIn = '0;
  logic [31:0] causeIn = '0;
  logic [31:0] ebaseIn = '0;
  logic [4:0]  vsIn = '0;
  logic [7:0]  irqPend = '0;
  logic        vecInt = 1'b0;
  logic        vecExt = 1'b0;
  logic [31:0] pcOut, statusOut, causeOut, epcOut, errorEpcOut, depcOut;
  logic        takenOut, errOut;

  int nChecks = 0;
  int nFails = 0;

  logic [31:0] mPc = '0, mSt = '0, mCa = '0, mEpc = '0, mErrEpc = '0, mDepc = '0;
  logic        mTaken = 1'b0, mErrFlag = 1'b0;

  always #4 clk = ~clk;

  trap_vector_unit u0 (.*);

  function automatic string tagOf(input logic [4:0] k, input logic exl);
    if (k > 5'd18) return "R13";
    if (k == 5'd18) return "R10";
    if (k >= 5'd16) return "R9";
    if (k == 5'd15) return "R11";
    if (k == 5'd11) return "R12";
    if (k == 5'd0) return "R5";
    if ((k == 5'd2 || k == 5'd3) && !exl) return "R3";
    if (exl) return "R7";
    return "R6";
  endfunction

  task automatic modelStep();
    logic [31:0] rpc, base, off, s, c;
    logic [7:0]  msk;
    int          v;
    logic        exl;
    mTaken = 1'b0; mErrFlag = 1'b0;
    if (!excValid) return;
    if (excKind > 5'd18) begin mErrFlag = 1'b1; return; end
    mTaken = 1'b1;
    exl = statusIn[1];
    rpc = (curPc | {31'b0, isaMode}) - (inDelaySlot ? (branch16 ? 32'd2 : 32'd4) : 32'd0);
    s = statusIn; c = causeIn;
    base = statusIn[22] ? 32'hBFC00200 : {ebaseIn[31:10], 10'b0};
    if (excKind <= 5'd15) begin
      if (!exl) begin mEpc = rpc; c[31] = inDelaySlot; s[1] = 1'b1; s[4:3] = 2'b00; end
      c[6:2] = (excKind == 5'd14) ? 5'd15 : (excKind == 5'd15) ? 5'd30 : excKind;
      if (excKind == 5'd11) c[29:28] = cpNum;
      off = 32'h180;
      if (excKind == 5'd0) begin
        msk = irqPend & statusIn[15:8];
        if (vecInt) begin
          v = 0;
          for (int i = 1; i < 8; i++) if (msk[i]) v = i;
        end else v = int'(msk);
        if (vecInt || vecExt) off = 32'h200 + 32'(v) * (32'(vsIn) * 32);
        else if (causeIn[23]) off = 32'h200;
      end
      if ((excKind == 5'd2 || excKind == 5'd3) && refillMiss && !exl) off = 32'h0;
      if (excKind == 5'd15) off = statusIn[22] ? 32'h100 : 32'h20000100;
      mPc = base + off;
    end else if (excKind <= 5'd17) begin
      mErrEpc = rpc; s[2] = 1'b1; s[22] = 1'b1; s[4:3] = 2'b00;
      if (excKind == 5'd17) s[20] = 1'b1;
      if (!exl) c[31] = 1'b0;
      mPc = 32'hBFC00000;
    end else begin
      mDepc = rpc; s[4:3] = 2'b00;
      if (!exl) c[31] = 1'b0;
      mPc = 32'hBFC00480;
    end
    mSt = s; mCa = c;
  endtask

  task automatic compare(input string tag);
    nChecks++;
    if (pcOut !== mPc || statusOut !== mSt || causeOut !== mCa || epcOut !== mEpc ||
        errorEpcOut !== mErrEpc || depcOut !== mDepc || takenOut !== mTaken || errOut !== mErrFlag) begin
      nFails++;
      $display("FAIL %s kind=%0d act pc=%h st=%h ca=%h epc=%h eepc=%h depc=%h tk=%b er=%b exp pc=%h st=%h ca=%h epc=%h eepc=%h depc=%h tk=%b er=%b",
        tag, excKind, pcOut, statusOut, causeOut, epcOut, errorEpcOut, depcOut, takenOut, errOut,
        mPc, mSt, mCa, mEpc, mErrEpc, mDepc, mTaken, mErrFlag);
    end
  endtask

  // inputs set at a falling edge; result compared one falling edge later
  task automatic fire(input string tag);
    excValid = 1'b1;
    modelStep();
    @(negedge clk);
    compare(tag);
    excValid = 1'b0;
  endtask

  task automatic idle();
    modelStep();
    @(negedge clk);
    compare("R2 idle hold");
  endtask

  task automatic setup(input logic [4:0] k, input logic [31:0] st, input logic [31:0] ca);
    excKind = k; statusIn = st; causeIn = ca;
    curPc = 32'h8000_1000; inDelaySlot = 1'b0; branch16 = 1'b0; isaMode = 1'b0;
    refillMiss = 1'b0; vecInt = 1'b0; vecExt = 1'b0; irqPend = '0; vsIn = '0;
    ebaseIn = 32'h8000_0000; cpNum = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // R2: ordinary kind, BEV clear then set
    setup(5'd8, 32'h0000_0018, 32'h0); ebaseIn = 32'h8000_37FF; fire("R2 ebase");
    setup(5'd9, 32'h0040_0000, 32'h0); fire("R2 boot base");
    idle();
    // R3: refill EXL clear vs set
    setup(5'd2, 32'h0, 32'h0); refillMiss = 1'b1; fire("R3 refill load");
    setup(5'd3, 32'h0000_0002, 32'h0); refillMiss = 1'b1; fire("R3 refill nested");
    // R4: IV set and clear
    setup(5'd0, 32'h0, 32'h0080_0000); fire("R4 iv set");
    setup(5'd0, 32'h0, 32'h0); fire("R4 iv clear");
    // R5: vectored internal, none pending and highest-wins
    setup(5'd0, 32'h0000_FF00, 32'h0); vecInt = 1'b1; vsIn = 5'd1; irqPend = 8'h01; fire("R5 vec none");
    setup(5'd0, 32'h0000_3F00, 32'h0); vecInt = 1'b1; vsIn = 5'd3; irqPend = 8'hF6; fire("R5 vec masked top");
    setup(5'd0, 32'h0000_FF00, 32'h0); vecExt = 1'b1; vsIn = 5'd2; irqPend = 8'h05; fire("R5 vec external");
    // R8: delay-slot resume forms
    setup(5'd10, 32'h0, 32'h0); inDelaySlot = 1'b1; fire("R8 delay 32");
    setup(5'd12, 32'h0, 32'h0); inDelaySlot = 1'b1; branch16 = 1'b1; isaMode = 1'b1; fire("R8 delay 16");
    // R11: cache error both BEV values
    setup(5'd15, 32'h0040_0000, 32'h0); fire("R11 cache boot");
    setup(5'd15, 32'h0, 32'h0); fire("R11 cache run");
    // R12, R6
    setup(5'd11, 32'h0, 32'h0); cpNum = 2'd2; fire("R12 cop unusable");
    setup(5'd14, 32'h0, 32'h0); fire("R6 fp code");
    // R7: nested, EPC and BD untouched
    setup(5'd4, 32'h0000_001A, 32'h8000_0000); inDelaySlot = 1'b0; curPc = 32'h1234; fire("R7 nested hold");
    // R9, R10
    setup(5'd16, 32'h0, 32'h8000_0000); fire("R9 nmi");
    setup(5'd17, 32'h0000_0002, 32'h8000_0000); fire("R9 soft reset");
    setup(5'd18, 32'h0000_0018, 32'h8000_0000); fire("R10 debug");
    // R13
    setup(5'd19, 32'h0, 32'h0); fire("R13 unknown 19");
    setup(5'd31, 32'h0040_0000, 32'hFFFF_FFFF); fire("R13 unknown 31");
    idle();

    for (int n = 0; n < 3000; n++) begin
      excKind = 5'($urandom_range(0, 22));
      curPc = $urandom & ~32'h1;
      inDelaySlot = 1'($urandom); branch16 = 1'($urandom); isaMode = 1'($urandom);
      refillMiss = 1'($urandom); cpNum = 2'($urandom);
      statusIn = $urandom; causeIn = $urandom; ebaseIn = $urandom;
      vsIn = 5'($urandom); irqPend = 8'($urandom);
      vecInt = ($urandom_range(0, 3) == 0); vecExt = ($urandom_range(0, 3) == 0);
      fire(tagOf(excKind, statusIn[1]));
      if ((n % 16) == 0) idle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule